// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block is the receive-side holding queue of a 16550-style serial port. The deserializer hands it one character per write strobe, together with three error tags: parity error, framing error and break. Each tag stays attached to its character. A tag reaches the line status bits only when its character becomes the oldest one in the queue, so software sees an error at the moment it is about to read the affected character.

The block drives the receive half of the line status register:

- data ready
- overrun
- parity
- framing
- break
- receiver-error summary

It also tells the interrupt logic two things. A level flag shows when the fill count has reached the trigger level chosen through the FIFO control write. A one-cycle pulse reports that no character has arrived and no read has taken place for four character times while data is still waiting.

A FIFO control write that carries the receive-reset bit empties the queue and cancels any pending timeout. Reading the line status register clears its sticky error bits.

Top module: `uart_rxq`

## Requirements
- R1: The queue holds up to 16 characters in arrival order. Each read of the receive buffer that finds the queue non-empty presents the oldest character on `rd_data` after the next clock edge. Before the first read, `rd_data` is zero.
- R2: A write strobe is an overrun when the queue is full and no read is accepted in the same cycle. The character is discarded, and `lsr_oe` and `lsr_err` both become set.
- R3: After any write strobe that is not in a queue-reset cycle, `lsr_dr` reads 1.
- R4: A character accepted into an empty queue ORs its tags into the status bits straight away: parity into `lsr_pe`, framing into `lsr_fe`, break into `lsr_bi`. If any of its tags is set, `lsr_err` is set as well.
- R5: A read that leaves characters behind keeps `lsr_dr` at 1 and ORs the new oldest character's tags into the status bits, following the same rule as R4. A read that leaves the queue empty clears `lsr_dr`.
- R6: A status read clears `lsr_oe`, `lsr_pe`, `lsr_fe`, `lsr_bi` and `lsr_err`. A flag raised by an event in that same cycle stays set.
- R7: `trig_hit` is 1 when the fill count is at or above the level selected by `fcr_trig`. Code 0 selects 1, code 1 selects 4, code 2 selects 8 and code 3 selects 14. The code is latched on every FIFO control write.
- R8: Every write strobe and every receive-buffer read restarts the timeout count. The timeout period is `char_clks` × 4 clocks. `tmo_pulse` is high for exactly one cycle after the period-th edge following the last restart, provided the queue is non-empty at that moment. The count then holds until the next restart. A `char_clks` value of 0 never fires.
- R9: A FIFO control write with `fcr_rx_reset` set empties the queue, clears `lsr_dr` and `trig_hit`, and cancels a pending timeout. A write strobe or a receive-buffer read in that same cycle is ignored.
- R10: A receive-buffer read of an empty queue leaves `rd_data` and the fill state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_wr | input | 1 | Character strobe from the deserializer |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error tag of the character |
| rx_frm_err | input | 1 | Framing error tag of the character |
| rx_brk | input | 1 | Break tag of the character |
| rbr_rd | input | 1 | Receive buffer read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_rx_reset | input | 1 | Receive queue reset field of the control write |
| fcr_trig | input | 2 | Trigger level code of the control write |
| char_clks | input | 12 | Clocks per character time |
| rd_data | output | 8 | Character returned by the last accepted read |
| lsr_dr | output | 1 | Data ready |
| lsr_oe | output | 1 | Overrun |
| lsr_pe | output | 1 | Parity error |
| lsr_fe | output | 1 | Framing error |
| lsr_bi | output | 1 | Break |
| lsr_err | output | 1 | Receiver error summary |
| trig_hit | output | 1 | Fill count at or above trigger level |
| tmo_pulse | output | 1 | Character timeout, one cycle |

## Verification
Every output is a register. Its new value is therefore due right after the edge that samples the stimulus: read data, status bits and the trigger flag all appear one clock after their strobe. The timeout pulse appears on the period-th edge after the last restart. The bench drives inputs on the falling edge and steps its reference model at each rising edge. It compares all outputs at the following falling edge, so every result is checked in exactly the cycle it is due. Directed sequences cover the cases a random mix reaches rarely: an overrun, a status read clearing the flags, tag hand-over on reads, every trigger code, an expiring timeout, a queue reset and a read of an empty queue.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Error tags stored next to each received character
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  // Trigger level selected by the two-bit control code
  function automatic logic [7:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    trig_level = 8'd1;
      2'd1:    trig_level = 8'd4;
      2'd2:    trig_level = 8'd8;
      default: trig_level = 8'd14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] mem [DEPTH];

  // Single write port, no reset on the array
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with synchronous output reset (read-first on collision)
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  rx_tag_t                  wr_tag,
  input  logic                     rbr_rd,
  input  logic                     fifo_rst,
  input  logic                     fcr_wr,
  input  logic [1:0]               fcr_trig,
  output logic                     ram_we,
  output logic [$clog2(DEPTH)-1:0] ram_waddr,
  output logic                     ram_re,
  output logic [$clog2(DEPTH)-1:0] ram_raddr,
  output logic                     ovr,
  output logic                     load_vld,
  output rx_tag_t                  load_tag,
  output logic                     occupied,
  output logic                     dr,
  output logic                     trig_hit
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] head, tail, tail_nx1;
  logic [CW-1:0] cnt, cnt_nx;
  logic [1:0]    code, code_nx;
  logic          rd_ok, wr_acc;
  rx_tag_t       tags [DEPTH];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    tail_nx1 = ptr_inc(tail);
    rd_ok    = !fifo_rst && rbr_rd && (cnt != '0);
    wr_acc   = !fifo_rst && wr_en && ((cnt != FULL) || rd_ok);
    ovr      = !fifo_rst && wr_en && !wr_acc;
    cnt_nx   = cnt + CW'(wr_acc) - CW'(rd_ok);
    code_nx  = fcr_wr ? fcr_trig : code;
    // Tags that become visible at the head this cycle
    load_vld = 1'b0;
    load_tag = wr_tag;
    if (wr_acc && (cnt == '0)) begin
      load_vld = 1'b1;
    end else if (rd_ok && (cnt > CW'(1))) begin
      load_vld = 1'b1;
      load_tag = tags[tail_nx1];
    end else if (rd_ok && wr_acc) begin
      load_vld = 1'b1;
    end
  end

  assign ram_we    = wr_acc;
  assign ram_waddr = head;
  assign ram_re    = rd_ok;
  assign ram_raddr = tail;
  assign occupied  = (cnt != '0);

  always_ff @(posedge clk) begin
    if (wr_acc) tags[head] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      code     <= '0;
      dr       <= 1'b0;
      trig_hit <= 1'b0;
    end else if (fifo_rst) begin
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      code     <= code_nx;
      dr       <= 1'b0;
      trig_hit <= 1'b0;
    end else begin
      if (wr_acc) head <= ptr_inc(head);
      if (rd_ok)  tail <= tail_nx1;
      cnt      <= cnt_nx;
      code     <= code_nx;
      dr       <= (cnt_nx != '0);
      trig_hit <= (cnt_nx >= CW'(trig_level(code_nx)));
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);  // R1

  AST_QRST_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |=> (!occupied && !dr && !trig_hit));  // R9

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
    ovr |=> occupied);  // R2

endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
  import uart_rxq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    lsr_rd,
  input  logic    ovr,
  input  logic    load_vld,
  input  rx_tag_t load_tag,
  output logic    oe,
  output logic    pe,
  output logic    fe,
  output logic    bi,
  output logic    err
);

  logic keep;
  logic tag_any;

  assign keep    = !lsr_rd;
  assign tag_any = load_vld && (load_tag != '0);

  // Clear on status read first, then new events of this cycle set their flags
  always_ff @(posedge clk) begin
    if (rst) begin
      oe  <= 1'b0;
      pe  <= 1'b0;
      fe  <= 1'b0;
      bi  <= 1'b0;
      err <= 1'b0;
    end else begin
      oe  <= (oe  && keep) || ovr;
      pe  <= (pe  && keep) || (load_vld && load_tag.par);
      fe  <= (fe  && keep) || (load_vld && load_tag.frm);
      bi  <= (bi  && keep) || (load_vld && load_tag.brk);
      err <= (err && keep) || ovr || tag_any;
    end
  end

  AST_OVR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ovr |=> (oe && err));  // R2

  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ovr && !load_vld) |=> (!oe && !pe && !fe && !bi && !err));  // R6

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int CLKW   = 12,
  parameter int FACTOR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            cancel,
  input  logic            occupied,
  input  logic [CLKW-1:0] char_clks,
  output logic            tmo_pulse
);

  localparam int PW = CLKW + $clog2(FACTOR + 1);

  logic [PW-1:0] period, cnt;
  logic          armed;

  assign period = PW'(char_clks) * PW'(FACTOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      cnt       <= '0;
      tmo_pulse <= 1'b0;
    end else begin
      tmo_pulse <= 1'b0;
      if (cancel) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (restart) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (period == '0) begin
          armed <= 1'b0;
        end else if (cnt == period - 1'b1) begin
          armed     <= 1'b0;
          tmo_pulse <= occupied;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TMO_OCC: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> $past(occupied));  // R8

  AST_TMO_ONCE: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |=> !tmo_pulse);  // R8

  AST_TMO_CANCEL: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !tmo_pulse);  // R9

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  parameter int CLKW       = 12,
  parameter int TMO_FACTOR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_wr,
  input  logic [DW-1:0]   rx_data,
  input  logic            rx_par_err,
  input  logic            rx_frm_err,
  input  logic            rx_brk,
  input  logic            rbr_rd,
  input  logic            lsr_rd,
  input  logic            fcr_wr,
  input  logic            fcr_rx_reset,
  input  logic [1:0]      fcr_trig,
  input  logic [CLKW-1:0] char_clks,
  output logic [DW-1:0]   rd_data,
  output logic            lsr_dr,
  output logic            lsr_oe,
  output logic            lsr_pe,
  output logic            lsr_fe,
  output logic            lsr_bi,
  output logic            lsr_err,
  output logic            trig_hit,
  output logic            tmo_pulse
);

  localparam int AW = $clog2(DEPTH);

  rx_tag_t       wtag, load_tag;
  logic          fifo_rst, ram_we, ram_re, ovr, load_vld, occupied;
  logic [AW-1:0] ram_waddr, ram_raddr;

  assign wtag     = {rx_brk, rx_frm_err, rx_par_err};
  assign fifo_rst = fcr_wr && fcr_rx_reset;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (rx_wr),
    .wr_tag    (wtag),
    .rbr_rd    (rbr_rd),
    .fifo_rst  (fifo_rst),
    .fcr_wr    (fcr_wr),
    .fcr_trig  (fcr_trig),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ovr       (ovr),
    .load_vld  (load_vld),
    .load_tag  (load_tag),
    .occupied  (occupied),
    .dr        (lsr_dr),
    .trig_hit  (trig_hit)
  );

  rxq_ram #(.W(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (rx_data),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (rd_data)
  );

  rxq_lsr u_lsr (
    .clk      (clk),
    .rst      (rst),
    .lsr_rd   (lsr_rd),
    .ovr      (ovr),
    .load_vld (load_vld),
    .load_tag (load_tag),
    .oe       (lsr_oe),
    .pe       (lsr_pe),
    .fe       (lsr_fe),
    .bi       (lsr_bi),
    .err      (lsr_err)
  );

  rxq_timer #(.CLKW(CLKW), .FACTOR(TMO_FACTOR)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (rx_wr || rbr_rd),
    .cancel    (fifo_rst),
    .occupied  (occupied),
    .char_clks (char_clks),
    .tmo_pulse (tmo_pulse)
  );

  AST_DR_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    (rx_wr && !fifo_rst) |=> lsr_dr);  // R3

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rbr_rd && !lsr_dr && !fifo_rst) |=> $stable(rd_data));  // R10

endmodule

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_wr = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rbr_rd = 1'b0, lsr_rd = 1'b0, fcr_wr = 1'b0, fcr_rx_reset = 1'b0;
  logic [1:0]  fcr_trig = '0;
  logic [11:0] char_clks = 12'd3;
  logic [7:0]  rd_data;
  logic        lsr_dr, lsr_oe, lsr_pe, lsr_fe, lsr_bi, lsr_err, trig_hit, tmo_pulse;

  int n_chk = 0;
  int n_fail = 0;
  int n_pulse = 0;

  always #5 clk = ~clk;

  uart_rxq u_dut (
    .clk(clk), .rst(rst), .rx_wr(rx_wr), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .fcr_wr(fcr_wr),
    .fcr_rx_reset(fcr_rx_reset), .fcr_trig(fcr_trig), .char_clks(char_clks),
    .rd_data(rd_data), .lsr_dr(lsr_dr), .lsr_oe(lsr_oe), .lsr_pe(lsr_pe),
    .lsr_fe(lsr_fe), .lsr_bi(lsr_bi), .lsr_err(lsr_err),
    .trig_hit(trig_hit), .tmo_pulse(tmo_pulse)
  );

  // Reference model state
  logic [7:0] q_data [16];
  logic [2:0] q_tag  [16];   // {brk, frm, par}
  int         m_tl, m_cnt, m_tc;
  logic [7:0] m_rd;
  logic [1:0] m_code;
  logic       m_dr, m_oe, m_pe, m_fe, m_bi, m_err, m_trig, m_pulse, m_armed;

  function automatic int level_of(input logic [1:0] c);
    case (c)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  task automatic apply_tag(input logic [2:0] t);
    m_pe  = m_pe  | t[0];
    m_fe  = m_fe  | t[1];
    m_bi  = m_bi  | t[2];
    m_err = m_err | (t != 3'b000);
  endtask

  task automatic model_step();
    logic frst, pulse_n;
    int   p;
    if (rst) begin
      m_tl = 0; m_cnt = 0; m_tc = 0; m_rd = '0; m_code = '0;
      m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_err = 0;
      m_trig = 0; m_pulse = 0; m_armed = 0;
      return;
    end
    frst    = fcr_wr && fcr_rx_reset;
    pulse_n = 1'b0;
    // R8 timer, judged on the fill state before this edge
    if (frst) begin
      m_armed = 0; m_tc = 0;
    end else if (rx_wr || rbr_rd) begin
      m_armed = 1; m_tc = 0;
    end else if (m_armed) begin
      p = int'(char_clks) * 4;
      if (p == 0) m_armed = 0;
      else if (m_tc == p - 1) begin
        m_armed = 0;
        pulse_n = (m_cnt != 0);
      end else m_tc++;
    end
    if (lsr_rd) begin  // R6
      m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_err = 0;
    end
    if (fcr_wr) m_code = fcr_trig;
    if (frst) begin  // R9
      m_cnt = 0; m_tl = 0; m_dr = 0; m_trig = 0;
    end else begin
      if (rbr_rd && m_cnt > 0) begin  // R5
        m_rd = q_data[m_tl];
        m_tl = (m_tl + 1) % 16;
        m_cnt--;
        if (m_cnt > 0) apply_tag(q_tag[m_tl]);
      end
      if (rx_wr) begin
        if (m_cnt < 16) begin
          q_data[(m_tl + m_cnt) % 16] = rx_data;
          q_tag[(m_tl + m_cnt) % 16]  = {rx_brk, rx_frm_err, rx_par_err};
          if (m_cnt == 0) apply_tag({rx_brk, rx_frm_err, rx_par_err});  // R4
          m_cnt++;
        end else begin  // R2
          m_oe = 1; m_err = 1;
        end
      end
      m_dr   = (m_cnt > 0);
      m_trig = (m_cnt >= level_of(m_code));
    end
    m_pulse = pulse_n;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1", "rd_data", 32'(rd_data), 32'(m_rd));
    chk("R3", "lsr_dr",  32'(lsr_dr),  32'(m_dr));
    chk("R2", "lsr_oe",  32'(lsr_oe),  32'(m_oe));
    chk("R4", "lsr_pe",  32'(lsr_pe),  32'(m_pe));
    chk("R4", "lsr_fe",  32'(lsr_fe),  32'(m_fe));
    chk("R4", "lsr_bi",  32'(lsr_bi),  32'(m_bi));
    chk("R2", "lsr_err", 32'(lsr_err), 32'(m_err));
    chk("R7", "trig_hit", 32'(trig_hit), 32'(m_trig));
    chk("R8", "tmo_pulse", 32'(tmo_pulse), 32'(m_pulse));
    if (tmo_pulse) n_pulse++;
  endtask

  task automatic idle();
    rx_wr = 0; rbr_rd = 0; lsr_rd = 0; fcr_wr = 0; fcr_rx_reset = 0;
    rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic put(input logic [7:0] d, input logic [2:0] t);
    rx_wr = 1; rx_data = d; {rx_brk, rx_frm_err, rx_par_err} = t;
    tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    tick();  // reset state, all outputs zero (R1)
    chk("R1", "reset rd_data", 32'(rd_data), 32'd0);

    // R4: first character with parity tag into empty queue
    put(8'hA0, 3'b001);
    chk("R4", "pe after first write", 32'(lsr_pe), 32'd1);
    for (int i = 1; i < 16; i++) put(8'hA0 + 8'(i), (i == 2) ? 3'b010 : 3'b000);
    chk("R1", "trig_hit at 16", 32'(trig_hit), 32'd1);
    put(8'hEE, 3'b100);  // R2 overrun
    chk("R2", "oe after overrun", 32'(lsr_oe), 32'd1);
    chk("R2", "bi not loaded on discard", 32'(lsr_bi), 32'd0);
    lsr_rd = 1; tick();
    chk("R6", "oe cleared", 32'(lsr_oe), 32'd0);
    chk("R6", "pe cleared", 32'(lsr_pe), 32'd0);
    rbr_rd = 1; tick();
    chk("R1", "first read data", 32'(rd_data), 32'hA0);
    rbr_rd = 1; tick();
    chk("R5", "fe from new head", 32'(lsr_fe), 32'd1);
    chk("R5", "dr kept", 32'(lsr_dr), 32'd1);
    // R7 each trigger code with 14 held
    for (int c = 0; c < 4; c++) begin
      fcr_wr = 1; fcr_trig = 2'(c); tick();
      chk("R7", "trig level 14 held", 32'(trig_hit), 32'd1);
    end
    rbr_rd = 1; tick();
    chk("R7", "trig below 14", 32'(trig_hit), 32'd0);
    // R8 timeout: period 12 after the read above
    n_pulse = 0;
    repeat (20) tick();
    chk("R8", "single timeout pulse", 32'(n_pulse), 32'd1);
    // R9 queue reset
    rx_wr = 1; rx_data = 8'h55; fcr_wr = 1; fcr_rx_reset = 1; fcr_trig = 2'd0; tick();
    chk("R9", "dr after reset", 32'(lsr_dr), 32'd0);
    chk("R9", "trig after reset", 32'(trig_hit), 32'd0);
    n_pulse = 0;
    repeat (20) tick();
    chk("R9", "no pulse after reset", 32'(n_pulse), 32'd0);
    // R10 read of empty queue
    rbr_rd = 1; tick();
    chk("R10", "rd_data held", 32'(rd_data), 32'hA2);
    chk("R10", "dr stays clear", 32'(lsr_dr), 32'd0);
    put(8'h3C, 3'b000);
    rbr_rd = 1; tick();
    chk("R5", "dr cleared when emptied", 32'(lsr_dr), 32'd0);
    chk("R1", "single char read", 32'(rd_data), 32'h3C);

    // Constrained random phase
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(99) < 2) char_clks = 12'($urandom_range(4));
      rx_wr   = ($urandom_range(99) < 30);
      rx_data = 8'($urandom);
      {rx_brk, rx_frm_err, rx_par_err} = ($urandom_range(9) == 0) ? 3'($urandom) : 3'b000;
      rbr_rd  = ($urandom_range(99) < 22);
      lsr_rd  = ($urandom_range(99) < 8);
      fcr_wr  = ($urandom_range(99) < 2);
      fcr_rx_reset = fcr_wr && ($urandom_range(1) == 0);
      fcr_trig = 2'($urandom);
      if ($urandom_range(99) < 5) begin
        idle();
        repeat ($urandom_range(20)) tick();
      end else tick();
    end
    summary();
    $finish;
  end

endmodule